// File: doc/BRIEF.md
# Command/Indication Channel Controller

This block serves two real-time status channels that ride in fixed slots of a frame-based time-division serial bus. The bus framing logic sits outside the block. Once per frame it pulses a frame strobe for one clock cycle. During that cycle it presents the received primary code (4 bits) and the received secondary code (6 bits). The block drives its two transmit codes continuously, so the framing logic can place them into their outgoing slots in every frame.

The primary channel filters noise with a two-frame confirmation. A new primary code is accepted only when the same value appears in two consecutive frames. Accepted codes go into a two-entry queue, so a second change that arrives before software reads the first one is kept. The secondary channel has no confirmation and can run 4 or 6 bits wide. In 4-bit mode it compares only the low four received bits, and its upper two transmit bits are forced to one. Each channel has a change flag. The secondary flag can be held back by an enable bit. The two flags combine into one level interrupt, which software services through a small read/write register port.

Top module: `ciChannelCtrl`

## Requirements
- R1: After reset, every register reads as follows: address 0 reads 0x0F (head code 0xF, both flags clear), address 1 reads 0x0F, address 2 reads 0x3F, and address 3 reads 0x3F (enable 0, 4-bit mode, code 0x3F). After reset, txPrimary is 0xF, txSecondary is 0x3F and irq is 0.
- R2: A write to address 1 loads bits [3:0] as the primary transmit code. txPrimary then carries that code in every cycle until the next write to address 1. Address 1 reads the code back in bits [3:0].
- R3: On a frame strobe, a received primary code is accepted only when two conditions hold: it equals the code received at the previous frame strobe, and it differs from the newest accepted code. An accepted code sets the primary change flag, which reads as bit 4 of address 0. The head code reads as bits [3:0] of address 0. A code present for a single frame is never accepted.
- R4: If the primary change flag is already set when a code is accepted, the code is queued behind the head. A clearing read then moves the queued code to the head and sets the primary change flag again. If a code is accepted while the queue is already full, it replaces the queued code.
- R5: A read of address 0 returns the flags as they stood before the read. The read then clears the primary change flag and the visible secondary change flag.
- R6: Bit 6 of address 3 selects the secondary width: 1 means 6-bit, 0 means 4-bit. In 6-bit mode txSecondary equals bits [5:0] of address 3. In 4-bit mode txSecondary is {2'b11, bits [3:0]}. Address 3 reads back {enable, width, code[5:0]}.
- R7: On every frame strobe the secondary change flag is set if the received secondary code differs from the code received at the previous strobe. Only bits [3:0] are compared in 4-bit mode; all 6 bits are compared in 6-bit mode. Address 2 reads the last received secondary code.
- R8: Bit 7 of address 3 enables the secondary flag. While it is 0, bit 5 of address 0 reads 0, the flag does not drive irq, and a read of address 0 leaves the flag pending. Setting the enable bit then reveals the pending flag.
- R9: irq is high exactly when the primary change flag is set, or when the secondary change flag is set and enabled. It stays high until a clearing read or a disabling write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStrobe | input | 1 | One-cycle pulse per frame; receive codes valid |
| rxPrimary | input | 4 | Received primary code slot |
| rxSecondary | input | 6 | Received secondary code slot |
| regRead | input | 1 | Register read strobe (side effects at the clock edge) |
| regWrite | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data, combinational from regAddr |
| txPrimary | output | 4 | Primary transmit code |
| txSecondary | output | 6 | Secondary transmit code |
| irq | output | 1 | Level interrupt |

## Verification
All state updates on the clock edge where a strobe is high, so a frame or write result is visible one cycle after the strobe and irq follows in that same cycle. regRdata is combinational. The bench therefore captures read data while the read strobe is high, before the edge that applies the clear, and checks the cleared state one cycle later. The bench drives and samples on the falling edge, so each check reads the settled value of the cycle in which that result is due.

// File: rtl/ciPkg.sv
package ciPkg;
  localparam int RegAddrW = 2;
  localparam logic [RegAddrW-1:0] AddrPriRx = 2'd0;
  localparam logic [RegAddrW-1:0] AddrPriTx = 2'd1;
  localparam logic [RegAddrW-1:0] AddrSecRx = 2'd2;
  localparam logic [RegAddrW-1:0] AddrSecTx = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic samplePri;
    logic sampleSec;
    logic loadHeadRx;
    logic loadHeadPend;
    logic loadPendRx;
    logic wrTxPri;
    logic wrTxSec;
  } ciStrobes_t;
endpackage

// File: rtl/ciDatapath.sv
module ciDatapath
  import ciPkg::*;
#(
  parameter int PriW = 4,
  parameter int SecW = 6,
  parameter int SecNarrowW = 4,
  parameter int DataW = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ciStrobes_t           stb,
  input  logic [PriW-1:0]      rxPri,
  input  logic [SecW-1:0]      rxSec,
  input  logic [RegAddrW-1:0]  regAddr,
  input  logic [DataW-1:0]     regWdata,
  input  logic                 priChg,
  input  logic                 secChgVis,
  input  logic                 pendValid,
  output logic                 priStable,
  output logic                 priNew,
  output logic                 secDiff,
  output logic                 secEn,
  output logic [PriW-1:0]      txPri,
  output logic [SecW-1:0]      txSec,
  output logic [DataW-1:0]     regRdata
);
  localparam int ForcedW = SecW - SecNarrowW;

  logic [PriW-1:0] lastPri, headCode, pendCode, txPriReg, newestCode;
  logic [SecW-1:0] secCode, txSecCode, cmpMask;
  logic            secWide;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastPri   <= '1;
      headCode  <= '1;
      pendCode  <= '1;
      secCode   <= '1;
      txPriReg  <= '1;
      txSecCode <= '1;
      secWide   <= 1'b0;
      secEn     <= 1'b0;
    end else begin
      if (stb.samplePri) lastPri <= rxPri;
      if (stb.loadHeadRx) headCode <= rxPri;
      else if (stb.loadHeadPend) headCode <= pendCode;
      if (stb.loadPendRx) pendCode <= rxPri;
      if (stb.sampleSec) secCode <= rxSec;
      if (stb.wrTxPri) txPriReg <= regWdata[PriW-1:0];
      if (stb.wrTxSec) begin
        txSecCode <= regWdata[SecW-1:0];
        secWide   <= regWdata[SecW];
        secEn     <= regWdata[SecW+1];
      end
    end
  end

  // compare against the most recently accepted primary code
  assign newestCode = pendValid ? pendCode : headCode;
  assign priStable  = (rxPri == lastPri);
  assign priNew     = (rxPri != newestCode);

  assign cmpMask = secWide ? {SecW{1'b1}} : {{ForcedW{1'b0}}, {SecNarrowW{1'b1}}};
  assign secDiff = |((rxSec ^ secCode) & cmpMask);

  assign txPri = txPriReg;
  assign txSec = secWide ? txSecCode
                         : {{ForcedW{1'b1}}, txSecCode[SecNarrowW-1:0]};

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      AddrPriRx: begin
        regRdata[PriW-1:0] = headCode;
        regRdata[PriW]     = priChg;
        regRdata[PriW+1]   = secChgVis;
      end
      AddrPriTx: regRdata[PriW-1:0] = txPriReg;
      AddrSecRx: regRdata[SecW-1:0] = secCode;
      default: begin
        regRdata[SecW-1:0] = txSecCode;
        regRdata[SecW]     = secWide;
        regRdata[SecW+1]   = secEn;
      end
    endcase
  end
endmodule

// File: rtl/ciControl.sv
module ciControl
  import ciPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                frameStrobe,
  input  logic                regRead,
  input  logic                regWrite,
  input  logic [RegAddrW-1:0] regAddr,
  input  logic                priStable,
  input  logic                priNew,
  input  logic                secDiff,
  input  logic                secEn,
  output ciStrobes_t          stb,
  output logic                priChg,
  output logic                pendValid,
  output logic                secChgRaw,
  output logic                secChgVis,
  output logic                irq
);
  logic clearRd, validNew, chgAfterRd, pendAfterRd, movePend;
  logic priChgD, pendValidD, secChgD;

  always_comb begin
    clearRd     = regRead && (regAddr == AddrPriRx);
    validNew    = frameStrobe && priStable && priNew;
    movePend    = clearRd && pendValid;
    chgAfterRd  = (priChg && !clearRd) || movePend;
    pendAfterRd = pendValid && !clearRd;

    stb              = '0;
    stb.samplePri    = frameStrobe;
    stb.sampleSec    = frameStrobe;
    stb.loadHeadPend = movePend;
    stb.loadHeadRx   = validNew && !chgAfterRd;
    stb.loadPendRx   = validNew && chgAfterRd;
    stb.wrTxPri      = regWrite && (regAddr == AddrPriTx);
    stb.wrTxSec      = regWrite && (regAddr == AddrSecTx);

    priChgD    = chgAfterRd || stb.loadHeadRx;
    pendValidD = pendAfterRd || stb.loadPendRx;
    secChgD    = (frameStrobe && secDiff) || (secChgRaw && !(clearRd && secEn));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      priChg    <= 1'b0;
      pendValid <= 1'b0;
      secChgRaw <= 1'b0;
    end else begin
      priChg    <= priChgD;
      pendValid <= pendValidD;
      secChgRaw <= secChgD;
    end
  end

  assign secChgVis = secChgRaw && secEn;
  assign irq       = priChg || secChgVis;
endmodule

// File: rtl/ciChannelCtrl.sv
module ciChannelCtrl
  import ciPkg::*;
#(
  parameter int PriW = 4,
  parameter int SecW = 6,
  parameter int SecNarrowW = 4,
  parameter int DataW = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                frameStrobe,
  input  logic [PriW-1:0]     rxPrimary,
  input  logic [SecW-1:0]     rxSecondary,
  input  logic                regRead,
  input  logic                regWrite,
  input  logic [RegAddrW-1:0] regAddr,
  input  logic [DataW-1:0]    regWdata,
  output logic [DataW-1:0]    regRdata,
  output logic [PriW-1:0]     txPrimary,
  output logic [SecW-1:0]     txSecondary,
  output logic                irq
);
  ciStrobes_t stb;
  logic priStable, priNew, secDiff, secEn;
  logic priChg, pendValid, secChgRaw, secChgVis;

  ciControl uCtrl (
    .clk, .rstN, .frameStrobe, .regRead, .regWrite, .regAddr,
    .priStable, .priNew, .secDiff, .secEn,
    .stb, .priChg, .pendValid, .secChgRaw, .secChgVis, .irq
  );

  ciDatapath #(
    .PriW(PriW), .SecW(SecW), .SecNarrowW(SecNarrowW), .DataW(DataW)
  ) uDp (
    .clk, .rstN, .stb,
    .rxPri(rxPrimary), .rxSec(rxSecondary),
    .regAddr, .regWdata,
    .priChg, .secChgVis, .pendValid,
    .priStable, .priNew, .secDiff, .secEn,
    .txPri(txPrimary), .txSec(txSecondary),
    .regRdata
  );
endmodule

// File: rtl/ciChannelCtrlChecker.sv
module ciChannelCtrlChecker #(
  parameter int SecW = 6,
  parameter int SecNarrowW = 4,
  parameter int DataW = 8,
  parameter int PriW = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             frameStrobe,
  input logic             regRead,
  input logic             regWrite,
  input logic [1:0]       regAddr,
  input logic [DataW-1:0] regRdata,
  input logic [PriW-1:0]  txPrimary,
  input logic [SecW-1:0]  txSecondary,
  input logic             irq,
  input logic             priStable,
  input logic             priChg,
  input logic             pendValid,
  input logic             secChgRaw,
  input logic             secDiff,
  input logic             secEn
);
  logic clearRd;
  assign clearRd = regRead && (regAddr == 2'd0);

  assert_tx_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !regWrite |=> ($stable(txPrimary) && $stable(txSecondary)));

  assert_single_frame_ignored_R3: assert property (@(posedge clk) disable iff (!rstN)
    (frameStrobe && !priStable && !clearRd) |=> $stable(priChg));

  assert_queue_refill_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pendValid && clearRd) |=> priChg);

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    (clearRd && !pendValid && !frameStrobe) |=> !priChg);

  assert_narrow_forced_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd3 && !regRdata[SecW]) |-> (txSecondary[SecW-1:SecNarrowW] == '1));

  assert_sec_immediate_R7: assert property (@(posedge clk) disable iff (!rstN)
    (frameStrobe && secDiff) |=> secChgRaw);

  assert_masked_kept_R8: assert property (@(posedge clk) disable iff (!rstN)
    (secChgRaw && !secEn) |=> secChgRaw);

  assert_irq_level_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !clearRd && !(regWrite && regAddr == 2'd3)) |=> irq);
endmodule

bind ciChannelCtrl ciChannelCtrlChecker #(
  .SecW(SecW), .SecNarrowW(SecNarrowW), .DataW(DataW), .PriW(PriW)
) i_ciChecker (
  .clk(clk), .rstN(rstN), .frameStrobe(frameStrobe), .regRead(regRead),
  .regWrite(regWrite), .regAddr(regAddr), .regRdata(regRdata),
  .txPrimary(txPrimary), .txSecondary(txSecondary), .irq(irq),
  .priStable(priStable), .priChg(priChg), .pendValid(pendValid),
  .secChgRaw(secChgRaw), .secDiff(secDiff), .secEn(secEn)
);

// File: tb/test_ciChannelCtrl.sv
`timescale 1ns/1ps
module test_ciChannelCtrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameStrobe = 1'b0;
  logic [3:0] rxPrimary = 4'hF;
  logic [5:0] rxSecondary = 6'h3F;
  logic       regRead = 1'b0;
  logic       regWrite = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic [3:0] txPrimary;
  logic [5:0] txSecondary;
  logic       irq;

  ciChannelCtrl i_ciChannelCtrl (
    .clk, .rstN, .frameStrobe, .rxPrimary, .rxSecondary, .regRead, .regWrite,
    .regAddr, .regWdata, .regRdata, .txPrimary, .txSecondary, .irq
  );

  always #2.5 clk = ~clk;

  int  nChecks = 0;
  int  nFail = 0;
  bit  finished = 1'b0;

  // expected state derived from the requirements
  logic [3:0] mHead, mPend, mLast, mTxP;
  logic       mPendV, mPriChg, mSecChg, mEn, mWide;
  logic [5:0] mSecCode, mTxS;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [5:0] expTxSec();
    return mWide ? mTxS : {2'b11, mTxS[3:0]};
  endfunction

  function automatic logic expIrq();
    return mPriChg || (mSecChg && mEn);
  endfunction

  function automatic logic [7:0] expReg(input logic [1:0] a);
    case (a)
      2'd0:    return {2'b00, mSecChg && mEn, mPriChg, mHead};
      2'd1:    return {4'h0, mTxP};
      2'd2:    return {2'b00, mSecCode};
      default: return {mEn, mWide, mTxS};
    endcase
  endfunction

  task automatic modelReset();
    mHead = 4'hF; mPend = 4'hF; mLast = 4'hF; mTxP = 4'hF;
    mPendV = 0; mPriChg = 0; mSecChg = 0; mEn = 0; mWide = 0;
    mSecCode = 6'h3F; mTxS = 6'h3F;
  endtask

  task automatic modelFrame(input logic [3:0] p, input logic [5:0] s);
    logic [3:0] newest;
    logic [5:0] mask;
    newest = mPendV ? mPend : mHead;
    if (p == mLast && p != newest) begin
      if (!mPriChg) begin mHead = p; mPriChg = 1; end
      else begin mPend = p; mPendV = 1; end
    end
    mLast = p;
    mask = mWide ? 6'h3F : 6'h0F;
    if (((s ^ mSecCode) & mask) != 6'h00) mSecChg = 1;
    mSecCode = s;
  endtask

  task automatic checkOuts(input string req);
    check(req, 32'(txPrimary), 32'(mTxP), "txPrimary");
    check(req, 32'(txSecondary), 32'(expTxSec()), "txSecondary");
    check(req, 32'(irq), 32'(expIrq()), "irq");
  endtask

  task automatic doFrame(input logic [3:0] p, input logic [5:0] s);
    @(negedge clk);
    frameStrobe = 1; rxPrimary = p; rxSecondary = s;
    @(negedge clk);
    frameStrobe = 0;
    modelFrame(p, s);
  endtask

  task automatic doWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrite = 1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrite = 0;
    if (a == 2'd1) mTxP = d[3:0];
    if (a == 2'd3) begin mTxS = d[5:0]; mWide = d[6]; mEn = d[7]; end
  endtask

  task automatic readCheck(input logic [1:0] a, input string req, output logic [7:0] got);
    logic [7:0] exp;
    exp = expReg(a);
    @(negedge clk);
    regRead = 1; regAddr = a;
    #1 got = regRdata;
    @(negedge clk);
    regRead = 0;
    check(req, 32'(got), 32'(exp), $sformatf("read addr %0d", a));
    if (a == 2'd0) begin
      mPriChg = 0;
      if (mEn) mSecChg = 0;
      if (mPendV) begin mHead = mPend; mPendV = 0; mPriChg = 1; end
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic [3:0] lastP;
    void'($urandom(32'h5EED1));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    readCheck(2'd0, "R1", rd); check("R1", 32'(rd), 32'h0F, "pri rx literal");
    readCheck(2'd1, "R1", rd);
    readCheck(2'd2, "R1", rd);
    readCheck(2'd3, "R1", rd); check("R1", 32'(rd), 32'h3F, "sec tx literal");
    checkOuts("R1");

    // R3 single frame not accepted, two frames accepted
    doFrame(4'h5, 6'h3F);
    readCheck(2'd0, "R3", rd); check("R3", 32'(rd), 32'h0F, "one frame ignored");
    doFrame(4'h5, 6'h3F);
    checkOuts("R9");
    check("R9", 32'(irq), 32'h1, "irq after accept");
    readCheck(2'd0, "R3", rd); check("R3", 32'(rd), 32'h15, "accepted code");
    readCheck(2'd0, "R5", rd); check("R5", 32'(rd), 32'h05, "flag cleared");
    checkOuts("R5");

    // R4 queue and overwrite
    doFrame(4'h7, 6'h3F); doFrame(4'h7, 6'h3F);
    doFrame(4'h9, 6'h3F); doFrame(4'h9, 6'h3F);
    doFrame(4'hA, 6'h3F); doFrame(4'hA, 6'h3F);
    readCheck(2'd0, "R4", rd); check("R4", 32'(rd), 32'h17, "head first");
    checkOuts("R4");
    readCheck(2'd0, "R4", rd); check("R4", 32'(rd), 32'h1A, "queued overwritten code");
    readCheck(2'd0, "R4", rd); check("R4", 32'(rd), 32'h0A, "queue drained");

    // R2 transmit primary
    doWrite(2'd1, 8'h03);
    checkOuts("R2");
    doFrame(4'hA, 6'h3F); doFrame(4'hA, 6'h3F);
    check("R2", 32'(txPrimary), 32'h3, "tx held across frames");
    readCheck(2'd1, "R2", rd);

    // R6 width selection
    doWrite(2'd3, 8'h85);
    check("R6", 32'(txSecondary), 32'h35, "narrow tx forced");
    readCheck(2'd3, "R6", rd); check("R6", 32'(rd), 32'h85, "readback");
    doWrite(2'd3, 8'hC5);
    check("R6", 32'(txSecondary), 32'h05, "wide tx");

    // R7 narrow comparison ignores upper bits, wide does not
    doWrite(2'd3, 8'h80);
    doFrame(4'hA, 6'h0F);
    readCheck(2'd0, "R7", rd); check("R7", 32'(rd), 32'h0A, "upper bits ignored");
    doFrame(4'hA, 6'h0E);
    check("R7", 32'(irq), 32'h1, "narrow change irq");
    readCheck(2'd0, "R7", rd); check("R7", 32'(rd), 32'h2A, "narrow change flag");
    readCheck(2'd2, "R7", rd); check("R7", 32'(rd), 32'h0E, "last rx");
    doWrite(2'd3, 8'hC0);
    doFrame(4'hA, 6'h2E);
    readCheck(2'd0, "R7", rd); check("R7", 32'(rd), 32'h2A, "wide change flag");

    // R8 masking
    doWrite(2'd3, 8'h40);
    doFrame(4'hA, 6'h11);
    checkOuts("R8");
    readCheck(2'd0, "R8", rd); check("R8", 32'(rd), 32'h0A, "masked reads 0");
    doWrite(2'd3, 8'hC0);
    check("R8", 32'(irq), 32'h1, "pending revealed");
    readCheck(2'd0, "R8", rd); check("R8", 32'(rd), 32'h2A, "pending shown");
    checkOuts("R8");

    // random mix
    lastP = 4'hA;
    for (int i = 0; i < 600; i++) begin
      int op;
      logic [3:0] p;
      op = $urandom_range(0, 9);
      if (op <= 4) begin
        p = ($urandom_range(0, 1) == 0) ? lastP : 4'($urandom_range(0, 15));
        lastP = p;
        doFrame(p, ($urandom_range(0, 2) == 0) ? 6'($urandom()) : mSecCode);
        checkOuts("R3");
      end else if (op <= 6) begin
        readCheck(2'd0, "R5", rd);
        checkOuts("R9");
      end else if (op == 7) begin
        readCheck(2'($urandom_range(1, 3)), "R7", rd);
      end else if (op == 8) begin
        doWrite(2'd1, 8'($urandom()));
        checkOuts("R2");
      end else begin
        doWrite(2'd3, 8'($urandom()));
        checkOuts("R6");
      end
    end

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule